// File: doc/BRIEF.md
# Two-Level IO Address Translator

This block turns a device DMA address into a physical address by walking two tables held in system memory. The top four address bits select an entry in a segment table. That entry points to a page table. Address bits 27:12 select an entry in the page table. The page entry supplies the real page number and the access rights. Both table reads go through one simple read port. The port takes a one-cycle read strobe and later returns the data with a valid pulse. Only one request is in flight at a time.

Software sets up the block through two configuration registers. The first is a table-origin register, which holds the enable bit and the base of the segment table. The second is a command register, which holds the translation-enable bit. Translation runs only when both of those bits are set. Otherwise requests pass through untranslated. Each request carries an address, a read/write direction and an 11-bit requester ID. The response arrives as a one-cycle done pulse. With the pulse come either the 59-bit physical address or a fault code.

Top module: `io_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0 and `mem_rd` is 0. Translation starts out disabled.
- R2: When origin bit 63 or command bit 47 is 0, an accepted request completes with `rsp_paddr` equal to the zero-extended request address and `rsp_fault` = 00. No memory read is issued.
- R3: With translation on, the first read goes to the address {origin[61:12], 12'h000} + 8 * addr[31:28].
- R4: A segment entry with bit 63 clear gives `rsp_fault` = 01 (segment fault) and `rsp_paddr` = 0. No second memory read is issued.
- R5: A segment entry whose page-size code in bits 2:0 is not 001 (4 KB) gives a segment fault. This covers the codes 011 (64 KB), 101 (1 MB) and 111 (16 MB).
- R6: If addr[27:21] is greater than segment-entry bits 11:5 (table length in 4 KB pages, minus one), the result is a segment fault.
- R7: The second read goes to the address {segment entry[61:12], 12'h000} + 8 * addr[27:12].
- R8: A write to a page entry with bit 63 clear, or a read from one with bit 62 clear, gives `rsp_fault` = 10 (page fault) and `rsp_paddr` = 0. An all-zero page entry therefore always faults.
- R9: A requester ID that differs from page-entry bits 10:0 gives a page fault.
- R10: A request that passes all checks returns `rsp_paddr` = {page entry[58:12], addr[11:0]} with `rsp_fault` = 00. Page-entry bits 61:59 and 11 do not affect the result.
- R11: Each accepted request gives exactly one single-cycle `rsp_done`. `req_ready` stays low from acceptance until the done cycle has passed. Requests presented while `req_ready` is low are ignored.
- R12: `cfg_we` with `cfg_sel` = 0 writes the origin register, and with `cfg_sel` = 1 writes the command register. Of the command register, only bit 47 has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the origin register, 1 selects the command register |
| cfg_wdata | input | 64 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | AW | Device DMA address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_id | input | 11 | Requester ID |
| mem_rd | output | 1 | One-cycle table read strobe |
| mem_addr | output | 62 | Table read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 2 | 00 none, 01 segment fault, 10 page fault |
| rsp_paddr | output | 59 | Physical address, 0 on a fault |

## Verification
The bench runs a set of requests through a table image that mixes read-only, write-only, all-zero and foreign-owner page entries. A design that swapped the read and write permission bits, or skipped the owner comparison, would return addresses where faults are due. Two boundary tests look at the table-length check. The first uses the last entry of a one-page table. The second uses the first entry past a two-page table. An off-by-one length compare would either fault a legal page or translate past the end of the table. Further tests cover a segment entry that is valid but uses a 64 KB code, the logged table-read addresses and counts, pass-through under each of the two disable bits, and requests presented while the block is busy. These catch wrong index scaling, a page fetch after a segment fault, memory traffic during pass-through, and a second accepted request.

// File: rtl/io_xlate.sv
module io_xlate #(
  parameter int AW    = 32,
  parameter int OWN_W = 11,
  localparam int PG_SH  = 12,
  localparam int SEG_SH = 28,
  localparam int MA_W   = 62,
  localparam int RPN_W  = 47,
  localparam int PA_W   = RPN_W + PG_SH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [63:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [OWN_W-1:0] req_id,
  output logic             mem_rd,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata,
  output logic             rsp_done,
  output logic [1:0]       rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  localparam int SEG_W   = AW - SEG_SH;
  localparam int PIDX_W  = SEG_SH - PG_SH;
  localparam int ENT_SH  = PG_SH - 3;
  localparam int LEN_W   = 7;
  localparam int LEN_LO  = 5;
  localparam int TE_BIT  = 47;
  localparam int ORG_EN  = 63;
  localparam int STE_V   = 63;
  localparam int PTE_W   = 63;
  localparam int PTE_R   = 62;
  localparam logic [2:0] PS_4K = 3'b001;
  localparam logic [1:0] F_NONE = 2'b00, F_SEG = 2'b01, F_PAGE = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_STE_RD, S_STE_WT, S_PTE_RD, S_PTE_WT, S_DONE} st_t;

  st_t                    st;
  logic [63:0]            origin_q;
  logic                   te_q;
  logic [AW-1:0]          a_q;
  logic                   w_q;
  logic [OWN_W-1:0]       id_q;
  logic [MA_W-PG_SH-1:0]  pt_base_q;
  logic [1:0]             fault_q;
  logic [PA_W-1:0]        paddr_q;

  wire              xl_on = origin_q[ORG_EN] & te_q;
  wire [SEG_W-1:0]  seg   = a_q[AW-1:SEG_SH];
  wire [PIDX_W-1:0] pidx  = a_q[SEG_SH-1:PG_SH];
  wire [LEN_W-1:0]  pg_of_tbl = pidx[PIDX_W-1:ENT_SH];

  wire ste_bad = !mem_rdata[STE_V]
               || (mem_rdata[2:0] != PS_4K)
               || (pg_of_tbl > mem_rdata[LEN_LO+LEN_W-1:LEN_LO]);
  wire pte_bad = (w_q ? !mem_rdata[PTE_W] : !mem_rdata[PTE_R])
               || (mem_rdata[OWN_W-1:0] != id_q);

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_STE_RD) || (st == S_PTE_RD);
  assign mem_addr  = (st == S_STE_RD)
                   ? {origin_q[MA_W-1:PG_SH], {PG_SH{1'b0}}} + MA_W'({seg, 3'b000})
                   : {pt_base_q, {PG_SH{1'b0}}} + MA_W'({pidx, 3'b000});
  assign rsp_done  = (st == S_DONE);
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      origin_q  <= '0;
      te_q      <= 1'b0;
      a_q       <= '0;
      w_q       <= 1'b0;
      id_q      <= '0;
      pt_base_q <= '0;
      fault_q   <= F_NONE;
      paddr_q   <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_sel) te_q <= cfg_wdata[TE_BIT];
        else         origin_q <= cfg_wdata;
      end
      case (st)
        S_IDLE: if (req_valid) begin
          a_q  <= req_addr;
          w_q  <= req_write;
          id_q <= req_id;
          if (xl_on) st <= S_STE_RD;
          else begin
            paddr_q <= PA_W'(req_addr);
            fault_q <= F_NONE;
            st      <= S_DONE;
          end
        end
        S_STE_RD: st <= S_STE_WT;
        S_STE_WT: if (mem_rvalid) begin
          if (ste_bad) begin
            fault_q <= F_SEG;
            paddr_q <= '0;
            st      <= S_DONE;
          end else begin
            pt_base_q <= mem_rdata[MA_W-1:PG_SH];
            st        <= S_PTE_RD;
          end
        end
        S_PTE_RD: st <= S_PTE_WT;
        S_PTE_WT: if (mem_rvalid) begin
          st <= S_DONE;
          if (pte_bad) begin
            fault_q <= F_PAGE;
            paddr_q <= '0;
          end else begin
            fault_q <= F_NONE;
            paddr_q <= {mem_rdata[PA_W-1:PG_SH], a_q[PG_SH-1:0]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic unused_bits;
  assign unused_bits = ^{origin_q[ORG_EN-1:MA_W], origin_q[PG_SH-1:0],
                         cfg_wdata[63:TE_BIT+1], cfg_wdata[TE_BIT-1:0],
                         mem_rdata[62], mem_rdata[4:3]};
endmodule

// File: rtl/io_xlate_chk.sv
module io_xlate_chk #(
  parameter int PA_W = 59
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_rd,
  input logic            rsp_done,
  input logic [1:0]      rsp_fault,
  input logic [PA_W-1:0] rsp_paddr
);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r11_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);
  a_r11_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r10_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_fault != 2'b11));
  a_r4_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fault != 2'b00) |-> (rsp_paddr == '0));
  a_r3_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r1_rd_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !req_ready);
endmodule

bind io_xlate io_xlate_chk #(.PA_W(PA_W)) u_chk (.*);

// File: tb/tb_io_xlate.sv
module tb_io_xlate;
  localparam int NV = 15;
  // {write, id[10:0], addr[31:0], fault[1:0], paddr[58:0]}
  localparam logic [104:0] VEC [NV] = '{
    {1'b0, 11'd5, 32'h0000_0ABC, 2'd0, 59'h0000_0001_2345_ABC}, // R10 read ok
    {1'b1, 11'd5, 32'h0000_0010, 2'd0, 59'h0000_0001_2345_010}, // R10 write ok
    {1'b0, 11'd5, 32'h0000_1FFF, 2'd0, 59'h0000_000A_BCDE_FFF}, // R8 read-only read
    {1'b1, 11'd5, 32'h0000_1000, 2'd2, 59'h0},                  // R8 write denied
    {1'b1, 11'd7, 32'h0000_2004, 2'd0, 59'h0000_0000_0777_004}, // R8 write-only write
    {1'b0, 11'd7, 32'h0000_2004, 2'd2, 59'h0},                  // R8 read denied
    {1'b1, 11'd6, 32'h0000_2004, 2'd2, 59'h0},                  // R9 owner mismatch
    {1'b0, 11'd0, 32'h0000_3000, 2'd2, 59'h0},                  // R8 zero entry
    {1'b0, 11'd0, 32'h001F_F123, 2'd0, 59'h7FF_FFFF_FFFF_F123}, // R10 R6 last entry
    {1'b0, 11'd0, 32'h0020_0000, 2'd1, 59'h0},                  // R6 past 1-page table
    {1'b0, 11'd1, 32'h1025_8456, 2'd0, 59'h0000_0000_0055_456}, // R6 R7 second page
    {1'b0, 11'd1, 32'h1040_0000, 2'd1, 59'h0},                  // R6 past 2-page table
    {1'b0, 11'd0, 32'h2000_0000, 2'd1, 59'h0},                  // R4 invalid segment
    {1'b0, 11'd0, 32'h3000_0000, 2'd1, 59'h0},                  // R5 64 KB code
    {1'b0, 11'd0, 32'h4000_0000, 2'd1, 59'h0}                   // R4 zero segment
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [63:0] cfg_wdata = '0;
  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = '0;
  logic [10:0] req_id = '0;
  logic req_ready, mem_rd, mem_rvalid, rsp_done;
  logic [61:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [1:0] rsp_fault;
  logic [58:0] rsp_paddr;

  always #4 clk = ~clk;

  io_xlate dut (.*);

  logic [63:0] mem [4096];
  logic p1, p2;
  logic [11:0] a1;
  logic [63:0] d2;
  int rd_cnt;
  logic [61:0] rd_log [8];
  assign mem_rvalid = p2;
  assign mem_rdata  = d2;
  always @(posedge clk) begin
    p1 <= mem_rd;
    a1 <= mem_addr[14:3];
    p2 <= p1;
    d2 <= mem[a1];
    if (mem_rd) begin
      rd_log[rd_cnt[2:0]] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic sel, input logic [63:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  logic got_done;
  logic [1:0] got_f;
  logic [58:0] got_pa;
  int got_rds, rd_base;
  task automatic do_req(input logic w, input logic [10:0] id, input logic [31:0] a);
    int n;
    @(negedge clk);
    rd_base = rd_cnt;
    req_valid = 1; req_write = w; req_id = id; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!rsp_done && n < 100) begin @(negedge clk); n++; end
    got_done = rsp_done; got_f = rsp_fault; got_pa = rsp_paddr;
    got_rds = rd_cnt - rd_base;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    p1 = 0; p2 = 0; a1 = '0; d2 = '0; rd_cnt = 0;
    mem[0] = 64'h8000_0000_0000_1001;
    mem[1] = 64'h8000_0000_0000_2021;
    mem[2] = 64'h0000_0000_0000_4001;
    mem[3] = 64'h8000_0000_0000_4003;
    mem[12'h200] = 64'hC000_0000_1234_5005;
    mem[12'h201] = 64'h4000_0000_ABCD_E005;
    mem[12'h202] = 64'h8000_0000_0077_7007;
    mem[12'h3FF] = 64'hFFFF_FFFF_FFFF_F800;
    mem[12'h658] = 64'hC000_0000_0005_5001;

    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", {63'd0, req_ready}, 64'd1);
    chk("R1 done", {63'd0, rsp_done}, 64'd0);
    chk("R1 mem_rd", {63'd0, mem_rd}, 64'd0);

    do_req(0, 11'd3, 32'h1234_5678);
    chk("R1 R2 pass-through paddr", {5'd0, got_pa}, 64'h1234_5678);
    chk("R2 pass-through fault", {62'd0, got_f}, 64'd0);
    chk("R2 pass-through no reads", 64'(got_rds), 64'd0);

    cfg(0, 64'h8000_0000_0000_0000);
    cfg(1, 64'hFFFF_7FFF_FFFF_FFFF);
    do_req(1, 11'd0, 32'h0000_0ABC);
    chk("R12 bit47 clear paddr", {5'd0, got_pa}, 64'h0ABC);
    chk("R12 bit47 clear no reads", 64'(got_rds), 64'd0);

    cfg(1, 64'h0000_8000_0000_0000);
    for (int v = 0; v < NV; v++) begin
      logic [104:0] e;
      e = VEC[v];
      do_req(e[104], e[103:93], e[92:61]);
      chk($sformatf("vec%0d done R11", v), {63'd0, got_done}, 64'd1);
      chk($sformatf("vec%0d fault R8", v), {62'd0, got_f}, {62'd0, e[60:59]});
      chk($sformatf("vec%0d paddr R10", v), {5'd0, got_pa}, {5'd0, e[58:0]});
      chk($sformatf("vec%0d reads R4", v), 64'(got_rds), (e[60:59] == 2'd1) ? 64'd1 : 64'd2);
    end

    do_req(0, 11'd1, 32'h1025_8456);
    chk("R3 segment entry address", {2'd0, rd_log[rd_base[2:0]]}, 64'h8);
    chk("R7 page entry address", {2'd0, rd_log[3'(rd_base + 1)]}, 64'h32C0);

    do_req(0, 11'd0, 32'h3000_0000);
    chk("R3 seg3 entry address", {2'd0, rd_log[rd_base[2:0]]}, 64'h18);
    chk("R5 one read only", 64'(got_rds), 64'd1);

    cfg(0, 64'h0000_0000_0000_0000);
    do_req(0, 11'd9, 32'hFFFF_FFFF);
    chk("R2 origin off paddr", {5'd0, got_pa}, 64'hFFFF_FFFF);
    chk("R2 origin off no reads", 64'(got_rds), 64'd0);
    cfg(0, 64'h8000_0000_0000_0000);

    begin
      int dones;
      logic [58:0] pa1;
      dones = 0; pa1 = '0;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_id = 11'd5; req_addr = 32'h0000_0ABC;
      @(negedge clk);
      req_addr = 32'h0000_1FFF;
      chk("R11 ready low when busy", {63'd0, req_ready}, 64'd0);
      @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      for (int c = 0; c < 30; c++) begin
        if (rsp_done) begin dones++; pa1 = rsp_paddr; end
        @(negedge clk);
      end
      chk("R11 single done", 64'(dones), 64'd1);
      chk("R11 busy request ignored", {5'd0, pa1}, 64'h1_2345_ABC);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule